// File: doc/BRIEF.md
# I2C Multi-Slot Slave Address Matcher

This block decides whether the first byte of an I2C transfer is addressed to this device. Four programmable address slots are held in small configuration registers. When the bus front end has shifted in the address byte, it raises a one-cycle strobe together with that byte. The matcher compares the upper seven bits against every enabled slot. On the next clock it reports whether there was a hit, which slot hit, and the direction bit taken from the byte.

Slot 0 is the only slot with a qualifier register. The qualifier widens what slot 0 accepts. In mask mode, chosen address bits are treated as don't-care. In range mode, slot 0 accepts every address from its own value up to an inclusive upper bound. Slots 1 to 3 always compare exactly. To answer the general call, any slot is loaded with address 0 and enabled. There is no separate enable for the general call. Bit-level shifting, acknowledge generation, START/STOP detection and the data phase are handled elsewhere.

Configuration uses a word-wide write port and a combinational read port. Word index 0 to 3 selects slot 0 to 3 and index 4 selects the qualifier. The other indices are unmapped.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset every slot reads 0x00000001 (disabled, address 0), the qualifier reads 0, and matchHit is 0.
- R2: A slot whose disable bit is 1 never matches, even when its stored address equals the received one.
- R3: Slots 1, 2 and 3 match only when the received bits 7:1 equal their stored address exactly.
- R4: With qualifier bit 0 = 0 (mask mode), slot 0 matches when received and stored addresses agree on every bit where the qualifier value in bits 7:1 is 0. A zero value gives an exact compare.
- R5: With qualifier bit 0 = 1 (range mode), slot 0 matches any received address A with slotAddr <= A <= bound, where bound is the qualifier bits 7:1. If the bound is below the slot address, slot 0 matches nothing.
- R6: When several enabled slots match, matchSlot reports the lowest-numbered one.
- R7: matchHit, matchSlot and matchRead update one clock after addrValid and hold until the next addrValid. matchRead is bit 0 of the strobed byte.
- R8: Read bits 31:8 of every register are always 0, and writes to those bits have no effect.
- R9: A slot enabled with address 0 matches the general-call byte 0x00 or 0x01.
- R10: A slot word holds the disable bit in bit 0 (0 = enabled) and the address in bits 7:1. Writes to word indices 5 to 7 change no register and those indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Write word index |
| cfgWrData | input | 32 | Write data |
| cfgRdAddr | input | 3 | Read word index |
| cfgRdData | output | 32 | Read data (combinational) |
| addrValid | input | 1 | One-cycle strobe: received address byte is present |
| addrByte | input | 8 | Received address byte, bits 7:1 address, bit 0 R/W |
| matchHit | output | 1 | Registered: the last strobed byte hit an enabled slot |
| matchSlot | output | 2 | Registered: lowest matching slot index |
| matchRead | output | 1 | Registered: R/W bit of the last strobed byte |

## Verification
The matcher is driven first with identical addresses in two slots, which separates correct priority from last-wins or OR-merged decoding. It is then driven with one address on both sides of a disable toggle, which shows that the disable bit gates the compare and not only the register storage. Slot 0 is swept across the edges of a two-bit mask and across the lower bound, the upper bound and the points just beyond them in range mode, including a bound below the base. These sweeps tell exact, masked and range comparison apart and expose off-by-one bound errors. General-call bytes and idle cycles between strobes check the zero address and the holding of the registered outputs.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
  localparam int SLOT_N  = 4;
  localparam int ADDR_W  = 7;
  localparam int REG_W   = ADDR_W + 1;
  localparam int IDX_W   = $clog2(SLOT_N);
  localparam int QUAL_IX = SLOT_N;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              off;
  } slot_t;

  typedef struct packed {
    logic [ADDR_W-1:0] val;
    logic              rangeMode;
  } qual_t;

  typedef struct packed {
    logic [SLOT_N-1:0] slotWr;
    logic              qualWr;
    logic              capture;
  } ctrl_t;
endpackage

// File: rtl/i2cam_ctrl.sv
module i2cam_ctrl
  import i2cam_pkg::*;
#(
  parameter int CFG_AW = 3
) (
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              addrValid,
  output ctrl_t             ctrl
);
  always_comb begin
    ctrl = '0;
    for (int i = 0; i < SLOT_N; i++) begin
      ctrl.slotWr[i] = cfgWrEn && (cfgAddr == CFG_AW'(i));
    end
    ctrl.qualWr  = cfgWrEn && (cfgAddr == CFG_AW'(QUAL_IX));
    ctrl.capture = addrValid;
  end
endmodule

// File: rtl/i2cam_dpath.sv
module i2cam_dpath
  import i2cam_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_t                   ctrl,
  input  logic [REG_W-1:0]        wrWord,
  input  logic [REG_W-1:0]        rxByte,
  output slot_t [SLOT_N-1:0]      slotCfg,
  output qual_t                   qualCfg,
  output logic                    hitQ,
  output logic [IDX_W-1:0]        slotQ,
  output logic                    rwQ
);
  logic [ADDR_W-1:0] rxAddr;
  logic [SLOT_N-1:0] slotHit;
  logic              anyHit;
  logic [IDX_W-1:0]  firstIdx;

  assign rxAddr = rxByte[REG_W-1:1];

  generate
    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotCfg[g] <= '{addr: '0, off: 1'b1};
        end else if (ctrl.slotWr[g]) begin
          slotCfg[g] <= slot_t'(wrWord);
        end
      end

      if (g == 0) begin : g_qualified
        logic inMask;
        logic inRange;
        assign inMask  = ((rxAddr ^ slotCfg[g].addr) & ~qualCfg.val) == '0;
        assign inRange = (rxAddr >= slotCfg[g].addr) && (rxAddr <= qualCfg.val);
        assign slotHit[g] = !slotCfg[g].off &&
                            (qualCfg.rangeMode ? inRange : inMask);
      end else begin : g_exact
        assign slotHit[g] = !slotCfg[g].off && (rxAddr == slotCfg[g].addr);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCfg <= '0;
    end else if (ctrl.qualWr) begin
      qualCfg <= qual_t'(wrWord);
    end
  end

  always_comb begin
    firstIdx = '0;
    for (int i = SLOT_N - 1; i >= 0; i--) begin
      if (slotHit[i]) firstIdx = IDX_W'(i);
    end
  end

  assign anyHit = |slotHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ  <= 1'b0;
      slotQ <= '0;
      rwQ   <= 1'b0;
    end else if (ctrl.capture) begin
      hitQ  <= anyHit;
      slotQ <= firstIdx;
      rwQ   <= rxByte[0];
    end
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2cam_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [CFG_AW-1:0] cfgRdAddr,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              addrValid,
  input  logic [REG_W-1:0]  addrByte,
  output logic              matchHit,
  output logic [IDX_W-1:0]  matchSlot,
  output logic              matchRead
);
  localparam int PAD_W = DATA_W - REG_W;

  ctrl_t              ctrl;
  slot_t [SLOT_N-1:0] slotCfg;
  qual_t              qualCfg;
  logic               slotAllOff;

  i2cam_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .addrValid (addrValid),
    .ctrl      (ctrl)
  );

  i2cam_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wrWord  (cfgWrData[REG_W-1:0]),
    .rxByte  (addrByte),
    .slotCfg (slotCfg),
    .qualCfg (qualCfg),
    .hitQ    (matchHit),
    .slotQ   (matchSlot),
    .rwQ     (matchRead)
  );

  always_comb begin
    slotAllOff = 1'b1;
    for (int i = 0; i < SLOT_N; i++) slotAllOff &= slotCfg[i].off;
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgRdAddr == CFG_AW'(QUAL_IX)) begin
      cfgRdData = {{PAD_W{1'b0}}, qualCfg};
    end else begin
      for (int i = 0; i < SLOT_N; i++) begin
        if (cfgRdAddr == CFG_AW'(i)) cfgRdData = {{PAD_W{1'b0}}, slotCfg[i]};
      end
    end
  end
endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk (
  input logic        clk,
  input logic        rstN,
  input logic        addrValid,
  input logic [7:0]  addrByte,
  input logic        matchHit,
  input logic [1:0]  matchSlot,
  input logic        matchRead,
  input logic [31:0] cfgRdData,
  input logic        slotAllOff
);
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> !matchHit);

  p_all_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && slotAllOff) |=> !matchHit);

  p_rw_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> (matchRead == $past(addrByte[0])));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> ($stable(matchHit) && $stable(matchSlot) && $stable(matchRead)));

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[31:8] == 24'h0);
endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrValid  (addrValid),
  .addrByte   (addrByte),
  .matchHit   (matchHit),
  .matchSlot  (matchSlot),
  .matchRead  (matchRead),
  .cfgRdData  (cfgRdData),
  .slotAllOff (slotAllOff)
);

// File: tb/i2c_addr_matcher_bench.sv
`timescale 1ns/1ps
module i2c_addr_matcher_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [2:0]  cfgRdAddr = '0;
  logic [31:0] cfgRdData;
  logic        addrValid = 1'b0;
  logic [7:0]  addrByte = '0;
  logic        matchHit;
  logic [1:0]  matchSlot;
  logic        matchRead;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_addr_matcher u_i2c_addr_matcher (.*);

  // behavioural reference model
  int mSlot[4];
  int mQual;
  bit expHit;
  int expSlot;
  bit expRd;

  function automatic bit slotMatches(int s, int a);
    int base = (mSlot[s] >> 1) & 127;
    if (mSlot[s] % 2 == 1) return 0;
    if (s != 0) return a == base;
    if (mQual % 2 == 1) return (a >= base) && (a <= ((mQual >> 1) & 127));
    return ((a ^ base) & ~((mQual >> 1) & 127) & 127) == 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mSlot[i] = 1;
      mQual = 0; expHit = 0; expSlot = 0; expRd = 0;
    end else begin
      if (addrValid) begin
        expHit = 0; expSlot = 0;
        for (int i = 3; i >= 0; i--) begin
          if (slotMatches(i, int'(addrByte[7:1]))) begin expHit = 1; expSlot = i; end
        end
        expRd = addrByte[0];
      end
      if (cfgWrEn && cfgAddr < 4) mSlot[cfgAddr] = int'(cfgWrData[7:0]);
      else if (cfgWrEn && cfgAddr == 4) mQual = int'(cfgWrData[7:0]);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      compared++;
      if (matchHit !== expHit || (expHit && matchSlot !== 2'(expSlot)) || matchRead !== expRd) begin
        mismatched++;
        $display("FAIL %s: hit/slot/rw actual %0b/%0d/%0b expected %0b/%0d/%0b",
                 curReq, matchHit, matchSlot, matchRead, expHit, expSlot, expRd);
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 3'(idx); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic strobe(input string req, input logic [6:0] a, input logic rw);
    curReq = req;
    @(negedge clk);
    addrValid = 1'b1; addrByte = {a, rw};
    @(negedge clk);
    addrValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rdChk(input string req, input int idx, input logic [31:0] exp);
    @(negedge clk);
    cfgRdAddr = 3'(idx);
    #1;
    compared++;
    if (cfgRdData !== exp) begin
      mismatched++;
      $display("FAIL %s: read idx %0d actual %h expected %h", req, idx, cfgRdData, exp);
    end
  endtask

  task automatic outChk(input string req, input logic h);
    compared++;
    if (matchHit !== h) begin
      mismatched++;
      $display("FAIL %s: matchHit actual %0b expected %0b", req, matchHit, h);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    for (int i = 0; i < 4; i++) rdChk("R1", i, 32'h1);
    rdChk("R1", 4, 32'h0);
    outChk("R1", 1'b0);

    // R2 and R9: all slots disabled, general call ignored
    strobe("R2", 7'h00, 1'b0);
    outChk("R2", 1'b0);

    // R6: two slots with same address, lowest wins; R7 rw bit
    wr(1, {24'h0, 7'h50, 1'b0});
    wr(2, {24'h0, 7'h50, 1'b0});
    strobe("R6", 7'h50, 1'b1);
    outChk("R6", 1'b1);
    repeat (4) @(negedge clk); // R7: hold across idle cycles
    // R2: disable slot 1, slot 2 takes over
    wr(1, {24'h0, 7'h50, 1'b1});
    strobe("R2", 7'h50, 1'b0);
    wr(2, {24'h0, 7'h50, 1'b1});
    strobe("R2", 7'h50, 1'b0);
    outChk("R2", 1'b0);

    // R9: general call on slot 3
    wr(3, {24'h0, 7'h00, 1'b0});
    strobe("R9", 7'h00, 1'b0);
    outChk("R9", 1'b1);
    strobe("R9", 7'h00, 1'b1);
    // R3: exact on slot 3
    strobe("R3", 7'h01, 1'b0);
    outChk("R3", 1'b0);

    // R4: slot 0 exact then masked
    wr(0, {24'h0, 7'h20, 1'b0});
    strobe("R4", 7'h20, 1'b0);
    strobe("R4", 7'h21, 1'b0);
    outChk("R4", 1'b0);
    wr(4, {24'h0, 7'h03, 1'b0});
    for (int a = 8'h1E; a <= 8'h25; a++) strobe("R4", 7'(a), 1'b0);

    // R5: range mode
    wr(4, {24'h0, 7'h2F, 1'b1});
    for (int a = 8'h1E; a <= 8'h31; a++) strobe("R5", 7'(a), 1'b1);
    wr(4, {24'h0, 7'h10, 1'b1});
    strobe("R5", 7'h20, 1'b0);
    outChk("R5", 1'b0);
    strobe("R5", 7'h10, 1'b0);
    outChk("R5", 1'b0);

    // R8: reserved bits
    wr(1, 32'hFFFF_FFA4);
    rdChk("R8", 1, 32'h0000_00A4);
    rdChk("R10", 1, 32'h0000_00A4);
    strobe("R3", 7'h52, 1'b0);
    outChk("R3", 1'b1);

    // R10: unmapped indices
    for (int i = 5; i < 8; i++) wr(i, 32'h0000_0000);
    rdChk("R10", 0, 32'h0000_0040);
    rdChk("R10", 4, 32'h0000_0021);
    rdChk("R10", 5, 32'h0);
    rdChk("R10", 7, 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule